// File: doc/BRIEF.md
# Banked RAM Built From Narrow Sub-Arrays

This block is an 8-word by 4-bit memory put together from four identical storage sub-arrays, each holding 4 words of 2 bits. The sub-arrays form two banks of two. The top address bit is decoded into active-low per-chip selects so that only one bank responds. The two low address bits go to every sub-array in parallel. In each bank, one sub-array stores data bits 1:0 and its partner stores bits 3:2.

Control uses three active-low strobes: chip select, write enable and output enable. Write enable and output enable are shared by all sub-arrays, and only the chip selects differ between banks. Write data and read data use separate ports, and a valid flag marks the read data. Writes are committed on the rising clock edge. Reads are combinational from the addressed word. Storage is cleared by reset so that results are deterministic.

Top module: `banked_ram`

## Requirements
- R1: After reset is released, every one of the 8 addresses reads back 4'h0.
- R2: On a rising clock edge with cs_ni=0 and we_ni=0, wdata_i is stored at addr_i. A later read of that address returns it.
- R3: While cs_ni=0, oe_ni=0 and we_ni=1, rdata_o shows the word stored at addr_i and rvalid_o=1 in the same cycle, with no clock edge needed.
- R4: Whenever the read condition of R3 does not hold, rdata_o=4'h0 and rvalid_o=0.
- R5: With cs_ni=1, no write happens whatever we_ni and wdata_i are. Every address keeps its previous word.
- R6: With cs_ni=0, we_ni=0 and oe_ni=0 together, the write takes place and no read is produced: rvalid_o=0 and rdata_o=4'h0.
- R7: addr_i[2] picks the bank: 0 selects the bank holding addresses 0-3 and 1 selects the bank holding 4-7. Never more than one bank is selected. A write to one bank leaves the other bank's words unchanged.
- R8: All 16 4-bit values written to any address read back bit for bit. Bits 1:0 travel through one sub-array of the bank and bits 3:2 through the other.
- R9: With cs_ni=0, we_ni=1 and oe_ni=1, the storage is untouched and the outputs stay at zero with rvalid_o=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; writes commit on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears storage |
| cs_ni | input | 1 | Active-low chip select |
| we_ni | input | 1 | Active-low write enable, shared by all sub-arrays |
| oe_ni | input | 1 | Active-low output enable, shared by all sub-arrays |
| addr_i | input | 3 | Word address; bit 2 selects the bank |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data, zero when no read is active |
| rvalid_o | output | 1 | High while rdata_o carries a valid read |

## Verification
Reads have no latency. rdata_o and rvalid_o follow the strobes and the address within the same cycle. The bench therefore drives each step's inputs on the falling edge and compares the outputs a short delay later, before the next rising edge. A write lands on the rising edge that closes its step. Its effect is due in the read step that follows, and the bench's reference model is updated only at that edge. Every step, including writes, deselected cycles and idle cycles, has its outputs compared against the model. This is how the zero-output and no-valid rules are covered during the cycles where they apply.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;
  localparam int unsigned SUB_AW = 2;
  localparam int unsigned SUB_DW = 2;
  localparam int unsigned SUB_DEPTH = 1 << SUB_AW;
endpackage

// File: rtl/ram_sub_array.sv
module ram_sub_array #(
  parameter int unsigned AW = banked_ram_pkg::SUB_AW,
  parameter int unsigned DW = banked_ram_pkg::SUB_DW,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic wr_en, rd_en;

  assign wr_en = ~cs_ni & ~we_ni;
  assign rd_en = ~cs_ni & ~oe_ni & we_ni;  // write wins over read

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (wr_en) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o  = rd_en ? mem_q[addr_i] : '0;
  assign rvalid_o = rd_en;

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !we_ni) |=> mem_q[$past(addr_i)] == $past(wdata_i));
  assert_no_stray_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || we_ni) |=> $stable(mem_q));
  assert_valid_strobes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (!cs_ni && !oe_ni && we_ni));
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned CHIPS     = 2,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                              cs_ni,
  input  logic [BANK_W-1:0]                 bank_i,
  output logic [NUM_BANKS-1:0][CHIPS-1:0]   chip_cs_no
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = ~cs_ni & (bank_i == BANK_W'(b));
    for (genvar c = 0; c < CHIPS; c++) begin : g_chip
      assign chip_cs_no[b][c] = ~hit;
    end
  end
endmodule

// File: rtl/banked_ram.sv
module banked_ram #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 4,
  localparam int unsigned SUB_AW    = banked_ram_pkg::SUB_AW,
  localparam int unsigned SUB_DW    = banked_ram_pkg::SUB_DW,
  localparam int unsigned NUM_BANKS = 1 << (ADDR_W - SUB_AW),
  localparam int unsigned CHIPS     = DATA_W / SUB_DW,
  localparam int unsigned BANK_W    = ADDR_W - SUB_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [BANK_W-1:0]                          bank_sel;
  logic [NUM_BANKS-1:0][CHIPS-1:0]            chip_cs_n;
  logic [NUM_BANKS-1:0][CHIPS-1:0][SUB_DW-1:0] chip_rdata;
  logic [NUM_BANKS-1:0][CHIPS-1:0]            chip_rvalid;
  logic [NUM_BANKS-1:0]                       bank_act;

  assign bank_sel = addr_i[ADDR_W-1:SUB_AW];

  bank_decoder #(.NUM_BANKS(NUM_BANKS), .CHIPS(CHIPS)) i_dec (
    .cs_ni      (cs_ni),
    .bank_i     (bank_sel),
    .chip_cs_no (chip_cs_n)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_act[b] = ~chip_cs_n[b][0];
    for (genvar c = 0; c < CHIPS; c++) begin : g_chip
      // chip c holds data lane c
      ram_sub_array #(.AW(SUB_AW), .DW(SUB_DW)) i_sub (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cs_ni    (chip_cs_n[b][c]),
        .we_ni    (we_ni),
        .oe_ni    (oe_ni),
        .addr_i   (addr_i[SUB_AW-1:0]),
        .wdata_i  (wdata_i[c*SUB_DW +: SUB_DW]),
        .rdata_o  (chip_rdata[b][c]),
        .rvalid_o (chip_rvalid[b][c])
      );
    end
  end

  assign rdata_o  = chip_rdata[bank_sel];
  assign rvalid_o = |chip_rvalid;

  assert_one_bank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_act));
  assert_bank_matches_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni) |-> bank_act[bank_sel]);
  assert_lanes_together_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chip_rvalid) == (rvalid_o ? CHIPS : 0));
  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> rdata_o == '0);
endmodule

// File: tb/test_banked_ram.sv
`timescale 1ns/1ps
module test_banked_ram;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [2:0] addr_i = '0;
  logic [3:0] wdata_i = '0;
  logic [3:0] rdata_o;
  logic       rvalid_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [3:0] model [8];

  always #2.5 clk_i = ~clk_i;

  banked_ram i_banked_ram (
    .clk_i, .rst_ni, .cs_ni, .we_ni, .oe_ni, .addr_i, .wdata_i, .rdata_o, .rvalid_o
  );

  // drive at negedge, check before next posedge, update model at posedge
  task automatic step(input logic cs, input logic we, input logic oe,
                      input logic [2:0] a, input logic [3:0] d, input string tag);
    logic       ev;
    logic [3:0] ed;
    @(negedge clk_i);
    cs_ni = cs; we_ni = we; oe_ni = oe; addr_i = a; wdata_i = d;
    #1;
    ev = !cs && !oe && we;
    ed = ev ? model[a] : 4'h0;
    total++;
    if (rdata_o !== ed || rvalid_o !== ev) begin
      bad++;
      $display("FAIL %s addr=%0d: rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
               tag, a, rdata_o, rvalid_o, ed, ev);
    end
    @(posedge clk_i);
    if (!cs && !we) model[a] = d;
  endtask

  function automatic logic [3:0] pat(input int a, input int k);
    return 4'((a * 7 + 5 + k * 3) & 15);
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 4'h0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int a = 0; a < 8; a++) step(0, 1, 0, 3'(a), 4'h0, "R1");

    for (int a = 0; a < 8; a++) step(0, 0, 1, 3'(a), pat(a, 0), "R2");
    for (int a = 0; a < 8; a++) step(0, 1, 0, 3'(a), 4'h0, "R3");

    // bank isolation: rewrite low bank, high bank untouched
    for (int a = 0; a < 4; a++) step(0, 0, 1, 3'(a), ~pat(a, 0), "R7");
    for (int a = 0; a < 8; a++) step(0, 1, 0, 3'(a), 4'h0, "R7");
    for (int a = 4; a < 8; a++) step(0, 0, 1, 3'(a), 4'(a * 3), "R7");
    for (int a = 0; a < 8; a++) step(0, 1, 0, 3'(a), 4'h0, "R7");

    // deselected write attempts
    for (int a = 0; a < 8; a++) step(1, 0, 0, 3'(a), 4'hA ^ 4'(a), "R5");
    for (int a = 0; a < 8; a++) step(1, 1, 0, 3'(a), 4'h5, "R4");
    for (int a = 0; a < 8; a++) step(0, 1, 0, 3'(a), 4'h0, "R5");

    // write and read strobes together
    for (int a = 0; a < 8; a++) step(0, 0, 0, 3'(a), pat(a, 2), "R6");
    for (int a = 0; a < 8; a++) step(0, 1, 0, 3'(a), 4'h0, "R6");

    // selected but idle
    for (int a = 0; a < 8; a++) step(0, 1, 1, 3'(a), 4'hF, "R9");
    for (int a = 0; a < 8; a++) step(0, 1, 0, 3'(a), 4'h0, "R9");

    // exhaustive data sweep per address
    for (int a = 0; a < 8; a++)
      for (int d = 0; d < 16; d++) begin
        step(0, 0, 1, 3'(a), 4'(d), "R8");
        step(0, 1, 0, 3'(a), 4'h0, "R8");
      end
    for (int a = 0; a < 8; a++) step(0, 1, 0, 3'(a), 4'h0, "R7");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule